// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master that moves 8-bit words and is driven by software through a few registers on a simple single-cycle memory-mapped bus. Software queues outgoing bytes in a transmit FIFO and chooses the target devices through an active-low select register. It picks one of the four clock-polarity and clock-phase combinations, then releases a transmit-inhibit bit. The shift engine then sends every queued byte, one after another, without further help from software. Each byte sent brings one byte back from MISO, and that byte goes into a receive FIFO for software to collect.

The SCK half-period is fixed when the block is built, as a count of system clocks. Software cannot change it. When the last queued byte has finished shifting and the transmit FIFO is empty, the block raises a single-cycle completion pulse. Each FIFO can be emptied by writing a control bit that clears itself. A manual select mode holds the select register's value on the pins at all times. In automatic mode the select lines are asserted only while bytes are moving.

Top module: `spi_byte_master`

## Requirements
- R1: After synchronous reset the control register reads 0x0100 (inhibit set, all else clear). The status register reads 0x05. All select lines are high, SCK is 0 and the completion pulse is low.
- R2: The word addresses are: 0 = control, 1 = status, 2 = transmit data (write), 3 = receive data (read), 4 = select. Read data appears on the cycle after the read strobe. Status bit 0 is receive empty, bit 1 is receive full, bit 2 is transmit empty, bit 3 is transmit full, and bit 4 always reads 0.
- R3: Control bit 8 is transmit inhibit. While it is set, no byte leaves the transmit FIFO and SCK does not toggle. Once it is cleared, all queued bytes are shifted with no further writes.
- R4: Control bit 3 sets SCK polarity and bit 4 sets phase. Bytes go out MSB first, with 16 SCK transitions per byte. With phase 0, data is sampled on the leading edge. With phase 1, data is sampled on the trailing edge. SCK rests at the polarity level whenever no byte is shifting.
- R5: Every byte sent pushes exactly one received byte into the receive FIFO. Each read of the receive data port pops one byte, oldest first.
- R6: A write to the transmit data port while the transmit FIFO is full is discarded.
- R7: Writing 1 to control bit 5 (transmit) or bit 6 (receive) empties that FIFO on the next cycle. The bit then reads back as 0.
- R8: With control bit 7 set, the select pins always equal the select register. With it clear, the pins equal the register only while bytes are shifting and are all high otherwise.
- R9: The completion output pulses for exactly one cycle, and only once, when the final queued byte finishes with the transmit FIFO empty.
- R10: Shifting runs only while control bit 1 (enable) and bit 2 (master) are both set. Otherwise the shifter stays idle and SCK sits at the polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | SEL_W | Active-low device selects |
| tx_done_irq | output | 1 | Single-cycle completion pulse |

## Verification
The bench loops MISO back inverted and decodes the bus with its own edge-aware monitor. It sweeps all four clock modes with bytes that include all-zeros and all-ones values. A shifter that sent LSB first or sampled on the wrong edge would return swapped or shifted bytes. A wrong SCK rest level would show up as an odd transition count per byte. The bench also covers:
- Bytes leaking out while inhibit is set.
- A fifth write slipping into a full four-entry FIFO, which would produce an extra byte on the wire.
- FIFO-reset bits that stick, or that fail to drop queued data.
- Select lines held low while idle in automatic mode.
- Completion pulses after every byte rather than only at the drain.
- Shifting while the enable bit is clear.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_STATUS = 3'd1;
  localparam logic [2:0] A_TXDATA = 3'd2;
  localparam logic [2:0] A_RXDATA = 3'd3;
  localparam logic [2:0] A_SELECT = 3'd4;

  localparam int CB_EN      = 1;
  localparam int CB_MASTER  = 2;
  localparam int CB_CPOL    = 3;
  localparam int CB_CPHA    = 4;
  localparam int CB_TXRST   = 5;
  localparam int CB_RXRST   = 6;
  localparam int CB_MANUAL  = 7;
  localparam int CB_INHIBIT = 8;

  localparam logic [15:0] CTRL_WMASK = 16'h01FE;
  localparam logic [15:0] CTRL_RESET = 16'h0100;
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic       hold,
  input  logic       cpol,
  input  logic       cpha,
  input  logic       tx_avail,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       tx_pop,
  output logic       rx_push,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  output logic       busy
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(HALF_DIV - 1);

  logic          busy_q, sck_q, mosi_q;
  logic [3:0]    edge_q;
  logic [CW-1:0] div_q;
  logic [7:0]    tx_sh, rx_sh, rx_next;
  logic          start, tick, sample_now, shift_now, last;

  assign start      = !busy_q && run && !hold && tx_avail;
  assign tick       = busy_q && (div_q == DIV_LAST);
  assign sample_now = tick && (cpha ? edge_q[0] : !edge_q[0]);
  assign shift_now  = tick && (cpha ? !edge_q[0] : (edge_q[0] && edge_q != 4'd15));
  assign last       = tick && (edge_q == 4'd15);
  assign rx_next    = {rx_sh[6:0], miso};

  assign tx_pop  = start;
  assign rx_push = last;
  assign rx_byte = cpha ? rx_next : rx_sh;
  assign sck     = sck_q;
  assign mosi    = mosi_q;
  assign busy    = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      div_q  <= '0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      tx_sh  <= '0;
      rx_sh  <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      edge_q <= '0;
      div_q  <= '0;
      sck_q  <= cpol;
    end else if (start) begin
      busy_q <= 1'b1;
      edge_q <= '0;
      div_q  <= '0;
      sck_q  <= cpol;
      if (!cpha) begin
        mosi_q <= tx_byte[7];
        tx_sh  <= {tx_byte[6:0], 1'b0};
      end else begin
        tx_sh  <= tx_byte;
      end
    end else if (busy_q) begin
      if (tick) begin
        div_q  <= '0;
        sck_q  <= ~sck_q;
        edge_q <= edge_q + 4'd1;
        if (sample_now) rx_sh <= rx_next;
        if (shift_now) begin
          mosi_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
        if (last) busy_q <= 1'b0;
      end else begin
        div_q <= div_q + CW'(1);
      end
    end else begin
      sck_q <= cpol;
    end
  end
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int SEL_W      = 32,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_DIV   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [2:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic [SEL_W-1:0] ss_n,
  output logic             tx_done_irq
);
  logic [15:0]      ctrl_q, ctrl_d;
  logic [SEL_W-1:0] sel_q, ss_n_q;
  logic [31:0]      sel_rd;
  logic             irq_q;

  logic       tx_clr, rx_clr, tx_push, rx_pop;
  logic [7:0] tx_dout, rx_dout, rx_byte;
  logic       tx_empty, tx_full, rx_empty, rx_full;
  logic       tx_pop, rx_push, busy, run;

  assign tx_clr  = ctrl_q[CB_TXRST];
  assign rx_clr  = ctrl_q[CB_RXRST];
  assign tx_push = bus_wr && (bus_addr == A_TXDATA);
  assign rx_pop  = bus_rd && (bus_addr == A_RXDATA);
  assign run     = ctrl_q[CB_EN] && ctrl_q[CB_MASTER];

  always_comb begin
    ctrl_d = ctrl_q;
    ctrl_d[CB_TXRST] = 1'b0;
    ctrl_d[CB_RXRST] = 1'b0;
    if (bus_wr && bus_addr == A_CTRL) ctrl_d = bus_wdata[15:0] & CTRL_WMASK;
  end

  always_comb begin
    sel_rd = '0;
    sel_rd[SEL_W-1:0] = sel_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RESET;
      sel_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      if (bus_wr && bus_addr == A_SELECT) sel_q <= bus_wdata[SEL_W-1:0];
    end
  end

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata[7:0]),
    .pop(tx_pop), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full)
  );

  byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(rx_clr),
    .push(rx_push), .din(rx_byte),
    .pop(rx_pop), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full)
  );

  spi_shift_core #(.HALF_DIV(HALF_DIV)) u_core (
    .clk(clk), .rst(rst), .run(run),
    .hold(ctrl_q[CB_INHIBIT]),
    .cpol(ctrl_q[CB_CPOL]), .cpha(ctrl_q[CB_CPHA]),
    .tx_avail(!tx_empty), .tx_byte(tx_dout), .miso(miso),
    .tx_pop(tx_pop), .rx_push(rx_push), .rx_byte(rx_byte),
    .sck(sck), .mosi(mosi), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      ss_n_q    <= '1;
      irq_q     <= 1'b0;
    end else begin
      if (bus_rd) begin
        case (bus_addr)
          A_CTRL:   bus_rdata <= {16'h0000, ctrl_q};
          A_STATUS: bus_rdata <= {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
          A_RXDATA: bus_rdata <= {24'd0, rx_dout};
          A_SELECT: bus_rdata <= sel_rd;
          default:  bus_rdata <= '0;
        endcase
      end
      ss_n_q <= (ctrl_q[CB_MANUAL] || busy || tx_pop) ? sel_q : '1;
      irq_q  <= rx_push && tx_empty;
    end
  end

  assign ss_n        = ss_n_q;
  assign tx_done_irq = irq_q;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk #(
  parameter int SEL_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             inhibit,
  input logic             run,
  input logic             busy,
  input logic             sck,
  input logic             cpol,
  input logic             tx_clr,
  input logic             rx_clr,
  input logic             tx_empty,
  input logic             rx_empty,
  input logic             manual,
  input logic [SEL_W-1:0] sel,
  input logic [SEL_W-1:0] ss_n,
  input logic             irq
);
  // R3: an idle shifter under inhibit stays idle
  p_inhibit_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (inhibit && !busy) |=> !busy);

  // R4: SCK rests at the polarity level between bytes
  p_sck_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  // R7: FIFO reset bits leave their FIFO empty
  p_txq_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    tx_clr |=> tx_empty);
  p_rxq_cleared_r7: assert property (@(posedge clk) disable iff (rst)
    rx_clr |=> rx_empty);

  // R8: manual select follows the register
  p_manual_ss_r8: assert property (@(posedge clk) disable iff (rst)
    (manual && $past(manual) && $stable(sel)) |-> (ss_n == sel));

  // R9: completion is a single-cycle pulse
  p_irq_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R10: disabled engine goes idle
  p_run_off_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !run |=> !busy);
endmodule

bind spi_byte_master spi_byte_master_chk #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst(rst),
  .inhibit(ctrl_q[8]), .run(run), .busy(busy), .sck(sck),
  .cpol(ctrl_q[3]), .tx_clr(tx_clr), .rx_clr(rx_clr),
  .tx_empty(tx_empty), .rx_empty(rx_empty),
  .manual(ctrl_q[7]), .sel(sel_q), .ss_n(ss_n), .irq(tx_done_irq)
);

// File: tb/spi_byte_master_tb.sv
module spi_byte_master_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 4;
  localparam int DEPTH = 4;
  localparam int HALF  = 2;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic sck, mosi, miso, tx_done_irq;
  logic [SEL_W-1:0] ss_n;

  assign miso = ~mosi;

  spi_byte_master #(.SEL_W(SEL_W), .FIFO_DEPTH(DEPTH), .HALF_DIV(HALF)) u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .mosi(mosi),
    .miso(miso), .ss_n(ss_n), .tx_done_irq(tx_done_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic b_cpol = 0, b_cpha = 0;
  int edge_cnt = 0, cap_n = 0, cap_bits = 0, irq_cnt = 0;
  logic [7:0] cap_byte = 0;
  logic [7:0] cap_q [16];

  always @(sck) begin
    if (!rst) begin
      logic lead;
      lead = (sck != b_cpol);
      edge_cnt++;
      if (lead != b_cpha) begin
        cap_byte = {cap_byte[6:0], mosi};
        cap_bits++;
        if (cap_bits == 8) begin
          if (cap_n < 16) cap_q[cap_n] = cap_byte;
          cap_n++;
          cap_bits = 0;
        end
      end
    end
  end

  always @(posedge clk) if (tx_done_irq) irq_cnt++;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_mon(input logic pol, input logic pha);
    b_cpol = pol; b_cpha = pha;
    edge_cnt = 0; cap_n = 0; cap_bits = 0; irq_cnt = 0;
  endtask

  function automatic logic [7:0] pat(input int m, input int k);
    if (k == 0) return 8'h00;
    if (k == 1) return 8'hFF;
    return 8'((m * 8'h47 + k * 8'h29) ^ 8'hC3);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] cv;
    logic [SEL_W-1:0] sv;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check("R1 sck", {31'd0, sck}, 0);
    check("R1 ss_n", {28'd0, ss_n}, 32'hF);
    check("R1 irq", {31'd0, tx_done_irq}, 0);
    bus_read(3'd0, rd); check("R1 ctrl", rd, 32'h0100);
    bus_read(3'd1, rd); check("R1/R2 status", rd, 32'h05);

    // R3 R4 R5 R6 R8 R9 sweep of all modes
    for (int m = 0; m < 4; m++) begin
      logic pol, pha;
      pol = m[1]; pha = m[0];
      cv = 16'h0106 | (16'(pol) << 3) | (16'(pha) << 4);
      sv = ~(SEL_W'(1) << m);
      bus_write(3'd0, {16'd0, cv});
      bus_write(3'd4, {28'd0, sv});
      idle(4);
      clear_mon(pol, pha);
      for (int k = 0; k < DEPTH; k++) bus_write(3'd2, {24'd0, pat(m, k)});
      bus_write(3'd2, 32'h0000_005C); // R6 dropped
      idle(40);
      check("R3 no edges under inhibit", edge_cnt, 0);
      check("R8 auto idle ss_n", {28'd0, ss_n}, 32'hF);
      bus_read(3'd1, rd); check("R2/R6 status tx full", rd, 32'h09);
      bus_write(3'd0, {16'd0, cv & 16'hFEFF});
      idle(10);
      check("R8 auto active ss_n", {28'd0, ss_n}, {28'd0, sv});
      idle(220);
      check("R3/R6 byte count", cap_n, DEPTH);
      check("R4 edge count", edge_cnt, 16 * DEPTH);
      for (int k = 0; k < DEPTH; k++)
        check($sformatf("R4 wire byte m%0d k%0d", m, k), {24'd0, cap_q[k]}, {24'd0, pat(m, k)});
      check("R4 sck idle level", {31'd0, sck}, {31'd0, pol});
      check("R9 single pulse", irq_cnt, 1);
      check("R8 auto after ss_n", {28'd0, ss_n}, 32'hF);
      bus_read(3'd1, rd); check("R2/R5 status rx full", rd, 32'h06);
      for (int k = 0; k < DEPTH; k++) begin
        bus_read(3'd3, rd);
        check($sformatf("R5 rx byte m%0d k%0d", m, k), rd, {24'd0, ~pat(m, k)});
      end
      bus_read(3'd1, rd); check("R5 status drained", rd, 32'h05);
    end

    // R7 transmit FIFO reset
    bus_write(3'd0, 32'h0106);
    idle(4); clear_mon(0, 0);
    for (int k = 0; k < 3; k++) bus_write(3'd2, 32'h33 + k);
    bus_write(3'd0, 32'h0126);
    bus_read(3'd0, rd); check("R7 txrst self clears", rd, 32'h0106);
    bus_read(3'd1, rd); check("R7 tx emptied", rd, 32'h05);
    bus_write(3'd0, 32'h0006);
    idle(100);
    check("R7 nothing sent after reset", edge_cnt, 0);

    // R7 receive FIFO reset
    bus_write(3'd0, 32'h0106);
    bus_write(3'd2, 32'h12); bus_write(3'd2, 32'h34);
    bus_write(3'd0, 32'h0006);
    idle(100);
    bus_read(3'd1, rd); check("R7 rx holds data", rd, 32'h04);
    bus_write(3'd0, 32'h0146);
    bus_read(3'd0, rd); check("R7 rxrst self clears", rd, 32'h0106);
    bus_read(3'd1, rd); check("R7 rx emptied", rd, 32'h05);

    // R8 manual select
    bus_write(3'd4, 32'hB);
    bus_write(3'd0, 32'h0186);
    idle(3);
    check("R8 manual idle ss_n", {28'd0, ss_n}, 32'hB);
    clear_mon(0, 0);
    bus_write(3'd2, 32'hC9); bus_write(3'd2, 32'h6E);
    bus_write(3'd0, 32'h0086);
    idle(10);
    check("R8 manual active ss_n", {28'd0, ss_n}, 32'hB);
    idle(100);
    check("R8 manual after ss_n", {28'd0, ss_n}, 32'hB);
    check("R8 manual bytes", cap_n, 2);
    bus_read(3'd3, rd); check("R5 manual rx0", rd, 32'h36);
    bus_read(3'd3, rd); check("R5 manual rx1", rd, 32'h91);

    // R10 enable clear holds the shifter
    bus_write(3'd0, 32'h0108);
    idle(4); clear_mon(1, 0);
    bus_write(3'd2, 32'hA7);
    bus_write(3'd0, 32'h000C);
    idle(100);
    check("R10 no edges when disabled", edge_cnt, 0);
    check("R10 sck at polarity", {31'd0, sck}, 1);
    bus_write(3'd0, 32'h000A);
    idle(100);
    check("R10 no edges without master", edge_cnt, 0);
    bus_write(3'd0, 32'h000E);
    idle(60);
    check("R10 enabled sends", cap_n, 1);
    check("R10 sent byte", {24'd0, cap_q[0]}, 32'hA7);
    bus_read(3'd3, rd); check("R5 rx after enable", rd, 32'h58);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule